// File: doc/BRIEF.md
# Compressed Instruction Legality Checker

This block looks at one 16-bit compressed instruction per cycle and decides whether it is a reserved encoding that must trap as illegal, or a valid breakpoint. The checks cover the encodings that are reserved because a register field is x0 or an immediate is zero. The block reports an illegal flag and a breakpoint flag, and it gives the trap unit a trap value. For an illegal encoding the trap value is the instruction bits, zero-extended to XLEN. For a breakpoint it is the program counter of that instruction.

Only the fields these checks need are decoded: the quadrant, funct3, bit 12, the rd/rs1 field, the rs2 field and the 6-bit immediate. The block does not expand instructions to their 32-bit form and does not execute them. A parameter chooses between a registered result stage with a latency of one cycle (the default) and a purely combinational path.

Top module: `cinsn_guard`

## Requirements
- R1: An instruction whose 16 bits are all zero is illegal, and its trap value is zero. Quadrant 0 (bits [1:0]=00) encodings with any bit set are not flagged.
- R2: In quadrant 1 (bits [1:0]=01) with funct3 (bits [15:13]) 000, the encoding is illegal when exactly one of two conditions holds: rd (bits [11:7]) is zero, or the immediate {bit 12, bits [6:2]} is zero.
- R3: In quadrant 1 with funct3 001 or 010, the encoding is illegal when rd is zero.
- R4: In quadrant 1 with funct3 011 and rd equal to 2, the encoding is illegal when the immediate is zero. With any other rd it is illegal when rd is zero or the immediate is zero.
- R5: In quadrant 1 with funct3 100 and bits [11:10] equal to 00 or 01, the encoding is illegal when the shift amount {bit 12, bits [6:2]} is zero. When bits [11:10] are 10 or 11 it is never flagged.
- R6: In quadrant 2 (bits [1:0]=10) with funct3 000, the encoding is illegal when the shift amount is zero or rd is zero.
- R7: In quadrant 2 with funct3 010 or 011, the encoding is illegal when rd is zero.
- R8: In quadrant 2 with funct3 100 and bit 12 clear, the encoding is illegal when the rs1/rd field is zero, for either value of rs2 (bits [6:2]).
- R9: In quadrant 2 with funct3 100 and bit 12 set, a zero rs1 field with a zero rs2 field (0x9002) is a breakpoint whose trap value is the PC. A zero rs1 field with a nonzero rs2 field is illegal. A nonzero rs1 field is never flagged.
- R10: The illegal and breakpoint flags are never both set. The trap value is the zero-extended instruction while illegal is set, and it is zero while neither flag is set.
- R11: With the default registered stage, every output follows its input by exactly one clock. When in_valid is low, or during reset, out_valid, both flags and the trap value are zero.
- R12: Quadrant 3 (bits [1:0]=11) and every funct3 not named above are never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 16 | Compressed instruction bits |
| in_pc | input | XLEN | Address of the instruction |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Reserved or illegal encoding |
| out_brk | output | 1 | Valid breakpoint |
| out_tval | output | XLEN | Trap value for the trap unit |

## Verification
A rule that decodes the wrong field, or compares against the wrong value, shows up as a wrong flag in the result cycle for that instruction, one clock after it is presented. The bench therefore presents, for every rule, the zero and nonzero values of each field that rule tests, including immediates whose only set bit is bit 12. A wrong trap-value select shows up as PC bits on an illegal result, or as instruction bits on a breakpoint, in the same cycle. A stale register shows up as a flag left set during an idle cycle that follows a flagged instruction.

// File: rtl/cinsn_pkg.sv
package cinsn_pkg;

  typedef enum logic [1:0] {
    QD_ZERO  = 2'b00,
    QD_ONE   = 2'b01,
    QD_TWO   = 2'b10,
    QD_WIDE  = 2'b11
  } quad_e;

  typedef struct packed {
    quad_e      quad;
    logic [2:0] f3;
    logic       b12;
    logic [4:0] rd;
    logic [4:0] rs2;
    logic       all_z;
    logic       rd_z;
    logic       rs2_z;
    logic       imm_z;
  } cfields_t;

endpackage

// File: rtl/cinsn_field_split.sv
module cinsn_field_split
  import cinsn_pkg::*;
(
  input  logic [15:0] insn,
  output cfields_t    fld
);
  always_comb begin
    fld.quad  = quad_e'(insn[1:0]);
    fld.f3    = insn[15:13];
    fld.b12   = insn[12];
    fld.rd    = insn[11:7];
    fld.rs2   = insn[6:2];
    fld.all_z = (insn == 16'h0000);
    fld.rd_z  = (insn[11:7] == 5'd0);
    fld.rs2_z = (insn[6:2] == 5'd0);
    fld.imm_z = ({insn[12], insn[6:2]} == 6'd0);
  end
endmodule

// File: rtl/cinsn_rule_eval.sv
module cinsn_rule_eval
  import cinsn_pkg::*;
(
  input  cfields_t fld,
  output logic     bad,
  output logic     brk
);
  localparam logic [4:0] SP_REG = 5'd2;

  always_comb begin
    bad = 1'b0;
    brk = 1'b0;
    unique case (fld.quad)
      QD_ZERO: bad = fld.all_z;
      QD_ONE: begin
        case (fld.f3)
          3'b000: bad = fld.rd_z ^ fld.imm_z;
          3'b001,
          3'b010: bad = fld.rd_z;
          3'b011: bad = (fld.rd == SP_REG) ? fld.imm_z : (fld.rd_z | fld.imm_z);
          3'b100: if (!fld.rd[4]) bad = fld.imm_z;
          default: ;
        endcase
      end
      QD_TWO: begin
        case (fld.f3)
          3'b000: bad = fld.imm_z | fld.rd_z;
          3'b010,
          3'b011: bad = fld.rd_z;
          3'b100: begin
            if (!fld.b12) begin
              bad = fld.rd_z;
            end else if (fld.rd_z) begin
              brk = fld.rs2_z;
              bad = !fld.rs2_z;
            end
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cinsn_result_stage.sv
module cinsn_result_stage #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic            bad,
  input  logic            brk,
  input  logic [15:0]     insn,
  input  logic [XLEN-1:0] pc,
  output logic            o_vld,
  output logic            o_bad,
  output logic            o_brk,
  output logic [XLEN-1:0] o_tval
);
  localparam int PADW = XLEN - 16;

  logic            n_bad, n_brk;
  logic [XLEN-1:0] n_tval;

  always_comb begin
    n_bad  = vld & bad;
    n_brk  = vld & brk & ~bad;
    n_tval = '0;
    if (n_bad)      n_tval = {{PADW{1'b0}}, insn};
    else if (n_brk) n_tval = pc;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          o_vld  <= 1'b0;
          o_bad  <= 1'b0;
          o_brk  <= 1'b0;
          o_tval <= '0;
        end else begin
          o_vld  <= vld;
          o_bad  <= n_bad;
          o_brk  <= n_brk;
          o_tval <= n_tval;
        end
      end
    end else begin : g_comb
      logic unused_ck;
      assign unused_ck = clk ^ rst;
      assign o_vld  = vld;
      assign o_bad  = n_bad;
      assign o_brk  = n_brk;
      assign o_tval = n_tval;
    end
  endgenerate
endmodule

// File: rtl/cinsn_guard.sv
module cinsn_guard
  import cinsn_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [15:0]     in_insn,
  input  logic [XLEN-1:0] in_pc,
  output logic            out_valid,
  output logic            out_illegal,
  output logic            out_brk,
  output logic [XLEN-1:0] out_tval
);
  cfields_t fld;
  logic     bad, brk;

  cinsn_field_split u_split (
    .insn (in_insn),
    .fld  (fld)
  );

  cinsn_rule_eval u_rules (
    .fld (fld),
    .bad (bad),
    .brk (brk)
  );

  cinsn_result_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst    (rst),
    .vld    (in_valid),
    .bad    (bad),
    .brk    (brk),
    .insn   (in_insn),
    .pc     (in_pc),
    .o_vld  (out_valid),
    .o_bad  (out_illegal),
    .o_brk  (out_brk),
    .o_tval (out_tval)
  );
endmodule

// File: rtl/cinsn_guard_sva.sv
module cinsn_guard_sva #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [15:0]     in_insn,
  input logic [XLEN-1:0] in_pc,
  input logic            out_valid,
  input logic            out_illegal,
  input logic            out_brk,
  input logic [XLEN-1:0] out_tval
);
  p_mutex_r10: assert property (@(posedge clk) disable iff (rst)
    !(out_illegal && out_brk));

  p_tval_high_r10: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_tval[XLEN-1:16] == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_illegal && !out_brk && out_tval == '0));

  generate
    if (REG_OUT) begin : g_seq
      p_zero_insn_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn == 16'h0000) |=> (out_illegal && out_tval == '0));

      p_brk_pc_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn == 16'h9002) |=> (out_brk && out_tval == $past(in_pc)));

      p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

      p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_illegal && !out_brk));
    end
  endgenerate
endmodule

bind cinsn_guard cinsn_guard_sva #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/test_cinsn_guard.sv
module test_cinsn_guard;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [15:0]     in_insn = '0;
  logic [XLEN-1:0] in_pc = '0;
  logic            out_valid, out_illegal, out_brk;
  logic [XLEN-1:0] out_tval;

  always #5 clk = ~clk;

  cinsn_guard #(.XLEN(XLEN), .REG_OUT(1'b1)) i_cinsn_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_pc(in_pc),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_brk(out_brk), .out_tval(out_tval)
  );

  typedef struct {
    logic [15:0]     insn;
    logic            ill;
    logic            brk;
    logic [XLEN-1:0] tval;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  logic [XLEN-1:0] pc_ctr = 64'h0000_0000_8000_0000;

  function automatic logic [15:0] mk(input logic [1:0] qd, input logic [2:0] f3,
                                     input logic b12, input logic [4:0] r,
                                     input logic [4:0] lo);
    return {f3, b12, r, lo, qd};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] insn, input bit ill, input bit brk, input string tag);
    exp_t e;
    @(negedge clk);
    pc_ctr    = pc_ctr + 64'd2;
    in_valid  = 1'b1;
    in_insn   = insn;
    in_pc     = pc_ctr;
    e.insn = insn;
    e.ill  = ill;
    e.brk  = brk;
    e.tval = ill ? {48'h0, insn} : (brk ? pc_ctr : '0);
    e.tag  = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      chk(!(out_illegal && out_brk), "R10", "both flags", {62'h0, out_illegal, out_brk}, 64'h0);
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected result", {63'h0, out_valid}, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_illegal == e.ill && out_brk == e.brk && out_tval == e.tval, e.tag,
            $sformatf("insn %h ill/brk=%b%b tval", e.insn, out_illegal, out_brk),
            out_tval, e.tval);
        if (out_illegal != e.ill || out_brk != e.brk)
          chk(1'b0, e.tag, "flags", {62'h0, out_illegal, out_brk}, {62'h0, e.ill, e.brk});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_illegal && !out_brk && out_tval == '0, "R11", "reset state",
        {61'h0, out_valid, out_illegal, out_brk}, 64'h0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R1
    drive(16'h0000, 1, 0, "R1");
    drive(mk(2'b00, 3'b010, 1'b0, 5'd9, 5'd8), 0, 0, "R1");
    // R2
    drive(mk(2'b01, 3'b000, 1'b0, 5'd0, 5'd0), 0, 0, "R2");
    drive(mk(2'b01, 3'b000, 1'b0, 5'd0, 5'd5), 1, 0, "R2");
    drive(mk(2'b01, 3'b000, 1'b0, 5'd5, 5'd0), 1, 0, "R2");
    drive(mk(2'b01, 3'b000, 1'b0, 5'd5, 5'd5), 0, 0, "R2");
    drive(mk(2'b01, 3'b000, 1'b1, 5'd3, 5'd0), 0, 0, "R2");
    // R3
    drive(mk(2'b01, 3'b001, 1'b0, 5'd0, 5'd1), 1, 0, "R3");
    drive(mk(2'b01, 3'b001, 1'b0, 5'd4, 5'd0), 0, 0, "R3");
    drive(mk(2'b01, 3'b010, 1'b1, 5'd0, 5'd3), 1, 0, "R3");
    drive(mk(2'b01, 3'b010, 1'b0, 5'd7, 5'd0), 0, 0, "R3");
    // R4
    drive(mk(2'b01, 3'b011, 1'b0, 5'd2, 5'd0), 1, 0, "R4");
    drive(mk(2'b01, 3'b011, 1'b0, 5'd2, 5'd1), 0, 0, "R4");
    drive(mk(2'b01, 3'b011, 1'b1, 5'd2, 5'd0), 0, 0, "R4");
    drive(mk(2'b01, 3'b011, 1'b0, 5'd0, 5'd1), 1, 0, "R4");
    drive(mk(2'b01, 3'b011, 1'b0, 5'd5, 5'd0), 1, 0, "R4");
    drive(mk(2'b01, 3'b011, 1'b0, 5'd5, 5'd1), 0, 0, "R4");
    // R5
    drive(mk(2'b01, 3'b100, 1'b0, 5'b00001, 5'd0), 1, 0, "R5");
    drive(mk(2'b01, 3'b100, 1'b0, 5'b00001, 5'd3), 0, 0, "R5");
    drive(mk(2'b01, 3'b100, 1'b0, 5'b01010, 5'd0), 1, 0, "R5");
    drive(mk(2'b01, 3'b100, 1'b1, 5'b01010, 5'd0), 0, 0, "R5");
    drive(mk(2'b01, 3'b100, 1'b0, 5'b10011, 5'd0), 0, 0, "R5");
    drive(mk(2'b01, 3'b100, 1'b0, 5'b11000, 5'd0), 0, 0, "R5");
    // R6
    drive(mk(2'b10, 3'b000, 1'b0, 5'd0, 5'd3), 1, 0, "R6");
    drive(mk(2'b10, 3'b000, 1'b0, 5'd4, 5'd0), 1, 0, "R6");
    drive(mk(2'b10, 3'b000, 1'b1, 5'd4, 5'd0), 0, 0, "R6");
    drive(mk(2'b10, 3'b000, 1'b0, 5'd4, 5'd2), 0, 0, "R6");
    // R7
    drive(mk(2'b10, 3'b010, 1'b0, 5'd0, 5'd4), 1, 0, "R7");
    drive(mk(2'b10, 3'b010, 1'b0, 5'd1, 5'd4), 0, 0, "R7");
    drive(mk(2'b10, 3'b011, 1'b1, 5'd0, 5'd0), 1, 0, "R7");
    drive(mk(2'b10, 3'b011, 1'b0, 5'd9, 5'd0), 0, 0, "R7");
    // R8
    drive(mk(2'b10, 3'b100, 1'b0, 5'd0, 5'd0), 1, 0, "R8");
    drive(mk(2'b10, 3'b100, 1'b0, 5'd1, 5'd0), 0, 0, "R8");
    drive(mk(2'b10, 3'b100, 1'b0, 5'd0, 5'd3), 1, 0, "R8");
    drive(mk(2'b10, 3'b100, 1'b0, 5'd3, 5'd3), 0, 0, "R8");
    // R9
    drive(16'h9002, 0, 1, "R9");
    drive(mk(2'b10, 3'b100, 1'b1, 5'd0, 5'd4), 1, 0, "R9");
    drive(mk(2'b10, 3'b100, 1'b1, 5'd5, 5'd0), 0, 0, "R9");
    drive(mk(2'b10, 3'b100, 1'b1, 5'd5, 5'd6), 0, 0, "R9");
    drive(16'h9002, 0, 1, "R9");
    // R12
    drive(16'hFFFF, 0, 0, "R12");
    drive(16'h0003, 0, 0, "R12");
    drive(mk(2'b01, 3'b101, 1'b0, 5'd0, 5'd0), 0, 0, "R12");
    drive(mk(2'b10, 3'b110, 1'b0, 5'd0, 5'd0), 0, 0, "R12");
    drive(mk(2'b10, 3'b001, 1'b0, 5'd0, 5'd0), 0, 0, "R12");
    // R10 / R11: flagged instruction, then an idle cycle carrying a zero word
    drive(16'h0000, 1, 0, "R10");
    @(negedge clk);
    in_valid = 1'b0;
    in_insn  = 16'h0000;
    @(negedge clk);
    chk(!out_valid && !out_illegal && !out_brk && out_tval == '0, "R11", "idle cycle",
        {61'h0, out_valid, out_illegal, out_brk}, 64'h0);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R11", "results outstanding", q.size(), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule